// File: doc/BRIEF.md
# Double Buffer with Stale-Entry Resync

This block holds two equally sized entry arrays. At any moment one of them is locked and serves a consumer through a read port. The other is unlocked and takes every write. A switch request swaps the two roles. Directly after a switch, the freshly unlocked array is missing whatever was written into its partner during the previous period. An internal resync engine closes that gap.

Each entry of each array carries a stale flag. A write stores its data in the unlocked array and clears that entry's flag there. It also raises the flag for the same address in the locked array. After a switch, the engine walks the addresses once, upward from zero, one per clock. For every entry flagged stale in the unlocked array, it copies the value from the locked array and clears the flag. Writes are still accepted during the walk. A write clears the flag, so the walk never overwrites it. When a write and the copy hit the same entry in the same clock, the write is kept and that copy is dropped.

A switch is only carried out while the engine is idle. A request made during a resync is remembered and takes effect once the walk has finished.

Top module: `dbuf_resync`

## Requirements
- R1: After reset, `lock_sel` is 0, `busy` and `done` are 0, and every entry of both arrays reads as 0.
- R2: `rd_data` always shows the entry at `rd_addr` in the locked array (array index `lock_sel`). A write goes only to the unlocked array, so it does not change `rd_data` until a switch locks that array.
- R3: A `swap_req` sampled while `busy` is 0 inverts `lock_sel` on that same clock edge, and `busy` is 1 from the next cycle on.
- R4: When a resync finishes, every entry that was stale in the unlocked array holds the value of the same entry in the locked array.
- R5: A resync visits addresses 0 to DEPTH-1 in ascending order, one per clock. `busy` is high for exactly DEPTH cycles. `done` is high for the one cycle right after `busy` falls.
- R6: A write made during a resync to an address the walk has not yet reached keeps its value, and the copy does not replace it.
- R7: A `swap_req` sampled while `busy` is 1 does not change `lock_sel` during the resync. It is held and carried out on the clock edge that ends the `done` cycle.
- R8: When a write during a resync targets the entry the walk is visiting in that cycle, the written value is kept and that entry's copy is cancelled.
- R9: A write during a resync marks the entry stale in the locked array, so the following resync carries the new value into that array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the unlocked array |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| swap_req | input | 1 | Request to exchange the locked and unlocked roles |
| rd_addr | input | AW | Read address into the locked array |
| rd_data | output | DW | Locked-array entry at `rd_addr` (combinational) |
| lock_sel | output | 1 | Index of the array currently locked |
| busy | output | 1 | Resync walk in progress |
| done | output | 1 | One-cycle pulse after a resync completes |

## Verification
The hardest situation to reach is a write that lands on the very entry the walk is copying in that clock. The bench gets there by counting cycles from the switch edge. The walk index equals the number of cycles since that edge, minus one, so the write is placed exactly in that cycle. During the same walk, a second write goes to a later address, and a switch request arrives mid-walk. Two further switches then show three things. The cancelled copy left the written value in place, the pending request was applied at the right edge, and the next resync carried both writes into the other array.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    typedef struct packed {
        logic lock;
        logic busy;
        logic pend;
        logic done;
    } dbr_flags_t;
endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
    import dbr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_req,
    output logic          lock,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        dbr_flags_t    f;
        logic [AW-1:0] ptr;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.f.done = 1'b0;
        if (st_q.f.busy) begin
            // walk one entry per clock; remember any switch request
            st_d.f.pend = st_q.f.pend | swap_req;
            st_d.ptr    = st_q.ptr + 1'b1;
            if (st_q.ptr == LAST) begin
                st_d.f.busy = 1'b0;
                st_d.f.done = 1'b1;
                st_d.ptr    = '0;
            end
        end else if (swap_req || st_q.f.pend) begin
            st_d.f.lock = ~st_q.f.lock;
            st_d.f.busy = 1'b1;
            st_d.f.pend = 1'b0;
            st_d.ptr    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock = st_q.f.lock;
    assign busy = st_q.f.busy;
    assign done = st_q.f.done;
    assign ptr  = st_q.ptr;
endmodule

// File: rtl/dbr_bank.sv
module dbr_bank #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_data,
    input  logic          b_en,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_data,
    input  logic          mark_en,
    input  logic [AW-1:0] mark_addr,
    input  logic [AW-1:0] r_addr,
    output logic [DW-1:0] r_data,
    input  logic [AW-1:0] s_addr,
    output logic [DW-1:0] s_data,
    output logic          s_stale
);
    typedef struct {
        logic [DW-1:0]    data [DEPTH];
        logic [DEPTH-1:0] stale;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (a_en) begin
            st_d.data[a_addr]  = a_data;
            st_d.stale[a_addr] = 1'b0;
        end
        if (b_en) begin
            st_d.data[b_addr]  = b_data;
            st_d.stale[b_addr] = 1'b0;
        end
        if (mark_en) st_d.stale[mark_addr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.data  <= '{default: '0};
            st_q.stale <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_data  = st_q.data[r_addr];
    assign s_data  = st_q.data[s_addr];
    assign s_stale = st_q.stale[s_addr];
endmodule

// File: rtl/dbuf_resync.sv
module dbuf_resync
    import dbr_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          swap_req,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          lock_sel,
    output logic          busy,
    output logic          done
);
    logic          lock;
    logic [AW-1:0] ptr;
    logic [DW-1:0] r_data [2];
    logic [DW-1:0] s_data [2];
    logic [1:0]    s_stale;
    logic [DW-1:0] src_data;
    logic          copy_en;

    dbr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_req (swap_req),
        .lock     (lock),
        .busy     (busy),
        .done     (done),
        .ptr      (ptr)
    );

    assign src_data = s_data[lock];
    // a host write to the walked entry cancels its copy (write wins)
    assign copy_en  = busy && s_stale[~lock] && !(wr_en && (wr_addr == ptr));

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_unl;
        assign is_unl = (lock != 1'(b));

        dbr_bank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .a_en      (wr_en && is_unl),
            .a_addr    (wr_addr),
            .a_data    (wr_data),
            .b_en      (copy_en && is_unl),
            .b_addr    (ptr),
            .b_data    (src_data),
            .mark_en   (wr_en && !is_unl),
            .mark_addr (wr_addr),
            .r_addr    (rd_addr),
            .r_data    (r_data[b]),
            .s_addr    (ptr),
            .s_data    (s_data[b]),
            .s_stale   (s_stale[b])
        );
    end

    assign rd_data  = r_data[lock];
    assign lock_sel = lock;
endmodule

// File: rtl/dbuf_resync_sva.sv
module dbuf_resync_sva (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic lock_sel
);
    assert_lock_held_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(lock_sel));

    assert_swap_starts_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_sel) |-> busy);

    assert_done_after_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind dbuf_resync dbuf_resync_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .lock_sel (lock_sel)
);

// File: tb/dbuf_resync_tb.sv
`timescale 1ns/10ps
module dbuf_resync_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          swap_req;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          lock_sel;
    logic          busy;
    logic          done;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // {addr, first write, value expected after the mid-walk writes}
    localparam logic [AW+2*DW-1:0] VEC [6] = '{
        {4'd1,  8'h11, 8'h11},
        {4'd3,  8'h33, 8'h33},
        {4'd6,  8'h66, 8'h66},
        {4'd9,  8'h99, 8'h99},
        {4'd12, 8'hC2, 8'hAB},
        {4'd15, 8'hF5, 8'h5A}
    };

    always #2.5 clk = ~clk;

    dbuf_resync #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .swap_req(swap_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .lock_sel(lock_sel), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #0.2;
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    initial begin
        #(20000 * 5.0);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        int done_early;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        swap_req = 1'b0; rd_addr = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 lock_sel", 32'(lock_sel), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        rd_chk("R1 rd addr5", 4'd5, 8'h00);

        // table writes into unlocked array 1
        for (int i = 0; i < 6; i++) begin
            wr_en   = 1'b1;
            wr_addr = VEC[i][AW+2*DW-1 -: AW];
            wr_data = VEC[i][2*DW-1 -: DW];
            step();
        end
        wr_en = 1'b0;
        // R2: locked array 0 is untouched
        for (int i = 0; i < 6; i++)
            rd_chk("R2 unlocked write hidden", VEC[i][AW+2*DW-1 -: AW], 8'h00);

        // switch S1 at edge E0
        swap_req = 1'b1;
        step();                       // N1: ptr = 0
        swap_req = 1'b0;
        chk("R3 lock_sel after swap", 32'(lock_sel), 1);
        chk("R3 busy after swap", 32'(busy), 1);
        for (int i = 0; i < 6; i++)
            rd_chk("R2 locked shows written", VEC[i][AW+2*DW-1 -: AW], VEC[i][2*DW-1 -: DW]);

        busy_cnt = 0;
        done_early = 0;
        for (int k = 1; k <= DEPTH; k++) begin
            // at negedge Nk the walk index is k-1
            if (busy) busy_cnt++;
            if (done) done_early++;
            if (lock_sel !== 1'b1) chk("R7 lock held during walk", 32'(lock_sel), 1);
            wr_en = 1'b0;
            if (k == 4)  begin wr_en = 1'b1; wr_addr = 4'd15; wr_data = 8'h5A; end // R6 ahead of walk
            if (k == 13) begin wr_en = 1'b1; wr_addr = 4'd12; wr_data = 8'hAB; end // R8 collision
            swap_req = (k == 6);                                                    // R7 pending
            step();
        end
        wr_en = 1'b0;
        swap_req = 1'b0;
        // N17
        chk("R5 busy cycles", 32'(busy_cnt), DEPTH);
        chk("R5 no early done", 32'(done_early), 0);
        chk("R5 busy low at end", 32'(busy), 0);
        chk("R5 done pulse", 32'(done), 1);
        chk("R7 lock unchanged in done cycle", 32'(lock_sel), 1);
        step();                       // N18: pending switch applied
        chk("R7 pending swap applied", 32'(lock_sel), 0);
        chk("R7 new walk busy", 32'(busy), 1);
        chk("R5 done single cycle", 32'(done), 0);
        // array 0 locked: copied values, with mid-walk writes kept
        for (int i = 0; i < 6; i++)
            rd_chk("R4 R6 R8 resynced content", VEC[i][AW+2*DW-1 -: AW], VEC[i][DW-1:0]);
        rd_chk("R4 untouched entry", 4'd0, 8'h00);

        repeat (DEPTH) step();        // N34
        chk("R5 second walk done", 32'(done), 1);
        step();
        swap_req = 1'b1;
        step();
        swap_req = 1'b0;
        chk("R3 third switch", 32'(lock_sel), 1);
        rd_chk("R9 collision write propagated", 4'd12, 8'hAB);
        rd_chk("R9 early write propagated", 4'd15, 8'h5A);
        rd_chk("R9 older entry kept", 4'd1, 8'h11);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule